// File: doc/BRIEF.md
# Ringing-to-idle transition sequencer

This block sits on the host side of a line-card switch controller. It owns the three command lines and the active-low shutdown override of that controller for the duration of one change from the ringing state to the idle/talk state. Outside such a change it passes the host's present command through unchanged.

A start request, taken only while the present command is the ringing code, launches the change. With the mode input low the change is make-before-break: the idle code is driven at once. With the mode input high the change is break-before-make. An all-off interval is held for a parameterised number of millisecond ticks before idle is driven. That interval is produced either by the all-off command code or, when the `USE_OVERRIDE` parameter is set, by pulling the override line low while the command moves underneath it. The override is modelled as an open-drain enable. Its released state is "not driven", never a driven high, so thermal protection in the switch stays active.

A busy flag covers the whole change. A one-cycle done pulse marks its end, and a one-cycle error pulse marks a refused start.

Top module: `ring_idle_seq`

## Requirements
- R1: After reset, busy, done, error and the override enable are all 0, and the command output equals the present command input.
- R2: While not busy, the command output equals the present command input combinationally.
- R3: A start request while not busy is accepted only when the present command is 3'b100. Otherwise the error output is 1 for exactly the next cycle and busy stays 0.
- R4: In make-before-break mode (mode input 0), the command output is 3'b000 with busy 1 in the single cycle after acceptance. Busy is 0 in the cycle after that.
- R5: In break-before-make mode with USE_OVERRIDE=0, the command output is 3'b101 from the cycle after acceptance until HOLD_MS tick pulses have been seen in that state. The tick in the acceptance cycle is not counted. The command output is then 3'b000 for one busy cycle.
- R6: In break-before-make mode with USE_OVERRIDE=1, the override enable is 1 and the command output is 3'b100 for one cycle. The override enable then stays 1 with command 3'b000 until HOLD_MS ticks are seen. After that comes one busy cycle with the override released and command 3'b000.
- R7: The override enable is 1 only during the override hold of R6. It is never 1 while idle, and never together with command 3'b101.
- R8: Done is 1 for exactly one cycle: the first cycle in which busy is 0 after a change.
- R9: Start requests that arrive while busy have no effect on the sequence or its timing, and raise no error.
- R10: The hold length is the parameter HOLD_MS (default 25, minimum 1), counted in millisecond tick pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a ringing-to-idle change |
| bbm_i | input | 1 | 1 = break-before-make, 0 = make-before-break |
| ms_tick_i | input | 1 | One-cycle pulse each millisecond |
| cmd_cur_i | input | 3 | Host's present command code |
| cmd_o | output | 3 | Command lines to the switch controller |
| ovr_low_en_o | output | 1 | 1 = pull override low, 0 = leave floating |
| busy_o | output | 1 | Change in progress |
| done_o | output | 1 | One-cycle pulse at the end of a change |
| err_o | output | 1 | One-cycle pulse for a refused start |

## Verification
Two instances run side by side, one for each hold method, and are compared every cycle against a behavioural model. A sweep of all eight command codes while idle separates pass-through from sequenced drive. Starts with non-ringing codes separate refusal from acceptance. A make-before-break start shows the single idle step. Break-before-make starts with sparse ticks, back-to-back ticks and a tick on the acceptance cycle pin down the exact hold count and the point where the override is released. Repeated starts during a hold show that a busy sequencer ignores them.

// File: rtl/rti_pkg.sv
package rti_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_HOLD_CMD  = 3'd1,
    ST_OVR_ENTER = 3'd2,
    ST_HOLD_OVR  = 3'd3,
    ST_FINISH    = 3'd4
  } seq_st_e;

  localparam logic [2:0] CMD_IDLE   = 3'b000;
  localparam logic [2:0] CMD_RING   = 3'b100;
  localparam logic [2:0] CMD_ALLOFF = 3'b101;

  // First state of an accepted change
  function automatic seq_st_e entry_state(logic bbm, logic use_ovr);
    if (!bbm)   return ST_FINISH;
    if (use_ovr) return ST_OVR_ENTER;
    return ST_HOLD_CMD;
  endfunction

  // Command code presented for each state
  function automatic logic [2:0] cmd_of(seq_st_e st, logic [2:0] cur);
    case (st)
      ST_IDLE:      return cur;
      ST_HOLD_CMD:  return CMD_ALLOFF;
      ST_OVR_ENTER: return CMD_RING;
      default:      return CMD_IDLE;
    endcase
  endfunction

  // Override pull-low enable for each state
  function automatic logic ovr_of(seq_st_e st);
    return (st == ST_OVR_ENTER) || (st == ST_HOLD_OVR);
  endfunction

  function automatic logic is_hold(seq_st_e st);
    return (st == ST_HOLD_CMD) || (st == ST_HOLD_OVR);
  endfunction

endpackage

// File: rtl/rti_start_gate.sv
module rti_start_gate (
  input  logic       start_i,
  input  logic       busy_i,
  input  logic [2:0] cmd_cur_i,
  output logic       accept_o,
  output logic       reject_o
);
  import rti_pkg::*;

  logic in_ring;
  always_comb begin
    in_ring  = (cmd_cur_i == CMD_RING);
    accept_o = start_i && !busy_i && in_ring;
    reject_o = start_i && !busy_i && !in_ring;
  end
endmodule

// File: rtl/rti_hold_timer.sv
module rti_hold_timer #(
  parameter int HOLD_MS = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int CW = (HOLD_MS < 2) ? 1 : $clog2(HOLD_MS);
  localparam logic [CW-1:0] LAST = CW'(HOLD_MS - 1);

  logic [CW-1:0] cnt_q;

  always_comb expire_o = run_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!run_i || expire_o) cnt_q <= '0;
    else if (tick_i)            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rti_out_drive.sv
module rti_out_drive (
  input  rti_pkg::seq_st_e st_i,
  input  logic [2:0]       cmd_cur_i,
  output logic [2:0]       cmd_o,
  output logic             ovr_low_en_o,
  output logic             busy_o
);
  import rti_pkg::*;

  always_comb begin
    cmd_o        = cmd_of(st_i, cmd_cur_i);
    ovr_low_en_o = ovr_of(st_i);
    busy_o       = (st_i != ST_IDLE);
  end
endmodule

// File: rtl/ring_idle_seq.sv
module ring_idle_seq #(
  parameter int HOLD_MS      = 25,
  parameter bit USE_OVERRIDE = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       bbm_i,
  input  logic       ms_tick_i,
  input  logic [2:0] cmd_cur_i,
  output logic [2:0] cmd_o,
  output logic       ovr_low_en_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o
);
  import rti_pkg::*;

  seq_st_e st_q, st_d;
  logic    accept, reject, hold_run, hold_expire;
  logic    done_q, err_q;

  rti_start_gate u_gate (
    .start_i   (start_i),
    .busy_i    (busy_o),
    .cmd_cur_i (cmd_cur_i),
    .accept_o  (accept),
    .reject_o  (reject)
  );

  always_comb hold_run = is_hold(st_q);

  rti_hold_timer #(.HOLD_MS(HOLD_MS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (hold_run),
    .tick_i   (ms_tick_i),
    .expire_o (hold_expire)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:      if (accept) st_d = entry_state(bbm_i, USE_OVERRIDE);
      ST_OVR_ENTER: st_d = ST_HOLD_OVR;
      ST_HOLD_CMD,
      ST_HOLD_OVR:  if (hold_expire) st_d = ST_FINISH;
      ST_FINISH:    st_d = ST_IDLE;
      default:      st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == ST_FINISH);
      err_q  <= reject;
    end
  end

  rti_out_drive u_drive (
    .st_i         (st_q),
    .cmd_cur_i    (cmd_cur_i),
    .cmd_o        (cmd_o),
    .ovr_low_en_o (ovr_low_en_o),
    .busy_o       (busy_o)
  );

  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/rti_checker.sv
module rti_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic [2:0] cmd_cur_i,
  input logic [2:0] cmd_o,
  input logic       ovr_low_en_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o
);
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> cmd_o == cmd_cur_i); // R2
  AST_ACCEPT_RING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(cmd_cur_i) == 3'b100); // R3
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !busy_o && $past(start_i) && $past(cmd_cur_i) != 3'b100); // R3
  AST_OVR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_low_en_o |-> busy_o && cmd_o != 3'b101); // R7
  AST_DONE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $fell(busy_o) && !ovr_low_en_o); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_FINISH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(cmd_o) == 3'b000 && !$past(ovr_low_en_o)); // R5
endmodule

bind ring_idle_seq rti_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .cmd_cur_i    (cmd_cur_i),
  .cmd_o        (cmd_o),
  .ovr_low_en_o (ovr_low_en_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o)
);

// File: tb/ring_idle_seq_bench.sv
module ring_idle_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, bbm = 1'b0, tick = 1'b0;
  logic [2:0] cur = 3'b010;

  logic [2:0] cmd [2];
  logic ovr [2], busy [2], done [2], err [2];

  int n_chk = 0, n_bad = 0, cyc = 0;

  localparam int HOLD_A = 25;
  localparam int HOLD_B = 3;
  int hold_of [2] = '{HOLD_A, HOLD_B};
  bit use_ov  [2] = '{1'b0, 1'b1};

  // model: 0 idle, 1 hold all-off code, 2 override entry, 3 override hold, 4 finish
  int ph [2], tk [2];
  bit m_done [2], m_err [2];

  always #5 clk = ~clk;

  ring_idle_seq #(.HOLD_MS(HOLD_A), .USE_OVERRIDE(1'b0)) u_ring_idle_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .bbm_i(bbm), .ms_tick_i(tick),
    .cmd_cur_i(cur), .cmd_o(cmd[0]), .ovr_low_en_o(ovr[0]), .busy_o(busy[0]),
    .done_o(done[0]), .err_o(err[0]));

  ring_idle_seq #(.HOLD_MS(HOLD_B), .USE_OVERRIDE(1'b1)) u_ring_idle_seq_ovr (
    .clk(clk), .rst_n(rst_n), .start_i(start), .bbm_i(bbm), .ms_tick_i(tick),
    .cmd_cur_i(cur), .cmd_o(cmd[1]), .ovr_low_en_o(ovr[1]), .busy_o(busy[1]),
    .done_o(done[1]), .err_o(err[1]));

  always @(posedge clk) begin
    cyc++;
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        ph[i] = 0; tk[i] = 0; m_done[i] = 0; m_err[i] = 0;
      end else begin
        m_done[i] = 0; m_err[i] = 0;
        case (ph[i])
          0: if (start) begin
               if (cur == 3'b100) begin
                 ph[i] = !bbm ? 4 : (use_ov[i] ? 2 : 1);
                 tk[i] = 0;
               end else m_err[i] = 1;
             end
          1, 3: if (tick) begin
               tk[i]++;
               if (tk[i] == hold_of[i]) ph[i] = 4;
             end
          2: begin ph[i] = 3; tk[i] = 0; end
          default: begin ph[i] = 0; m_done[i] = 1; end
        endcase
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    for (int i = 0; i < 2; i++) begin
      int ecmd;
      string ctag;
      case (ph[i])
        0: begin ecmd = cur;    ctag = "R2"; end
        1: begin ecmd = 3'b101; ctag = "R5"; end
        2: begin ecmd = 3'b100; ctag = "R6"; end
        3: begin ecmd = 3'b000; ctag = "R6"; end
        default: begin ecmd = 3'b000; ctag = "R4"; end
      endcase
      chk(ctag, $sformatf("cmd[%0d]", i), cmd[i], ecmd);
      chk("R7", $sformatf("ovr[%0d]", i), ovr[i], (ph[i] == 2 || ph[i] == 3) ? 1 : 0);
      chk("R9", $sformatf("busy[%0d]", i), busy[i], (ph[i] != 0) ? 1 : 0);
      chk("R8", $sformatf("done[%0d]", i), done[i], m_done[i]);
      chk("R3", $sformatf("err[%0d]", i), err[i], m_err[i]);
    end
  endtask

  // compare at the falling edge, then drive the next inputs
  task automatic step(input logic s, input logic b, input logic t, input logic [2:0] c);
    @(negedge clk);
    compare_all();
    start = s; bbm = b; tick = t; cur = c;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2; i++) begin // R1 reset state
      chk("R1", "cmd", cmd[i], 3'b010);
      chk("R1", "busy", busy[i], 0);
      chk("R1", "ovr", ovr[i], 0);
      chk("R1", "done", done[i], 0);
      chk("R1", "err", err[i], 0);
    end
    rst_n = 1'b1;
    // R2 pass-through sweep
    for (int c = 0; c < 8; c++) step(0, 0, c[0], 3'(c));
    // R3 refused starts
    step(1, 0, 0, 3'b000); step(0, 0, 0, 3'b000);
    step(1, 1, 0, 3'b101); step(0, 0, 0, 3'b101);
    // R4 make-before-break
    step(0, 0, 0, 3'b100); step(1, 0, 0, 3'b100);
    step(0, 0, 0, 3'b100);
    for (int k = 0; k < 4; k++) step(0, 0, 0, 3'b000);
    // R5 R6 R10 break-before-make, sparse ticks, tick on acceptance cycle, R9 repeated starts
    step(0, 1, 0, 3'b100); step(1, 1, 1, 3'b100);
    for (int k = 0; k < 110; k++) step((k % 17) == 5, 1, (k % 3) == 0, 3'b100);
    for (int k = 0; k < 4; k++) step(0, 0, 0, 3'b000);
    // back-to-back ticks
    step(1, 1, 1, 3'b100);
    for (int k = 0; k < 40; k++) step(k == 2, 1, 1, 3'b100);
    step(0, 0, 0, 3'b000);
    // make-before-break while the other hold method is still idle-ready
    step(1, 0, 1, 3'b100);
    for (int k = 0; k < 6; k++) step(k == 0, 0, 1, 3'b000);
    step(0, 0, 0, 3'b011);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule